// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory

This block keeps coherence bookkeeping for a set of memory lines. Each line's entry lists its sharers as a small fixed set of node-number pointers, each `log2(NODES)` bits wide. There is no per-node presence vector, so the storage per line grows with the logarithm of the node count rather than with the count itself. Each entry also carries a modified flag, a flag that marks the sharer list as overflowed, and a round-robin victim index.

A requester presents one operation at a time: a shared read or an exclusive write on a line. The parameter `BCAST_MODE` picks what happens when a read arrives and every pointer is already in use:
- With `BCAST_MODE = 0`, one listed sharer is invalidated and its slot is given to the newcomer.
- With `BCAST_MODE = 1`, the entry is marked as overflowed. A later write on that line then invalidates every node.

Invalidation targets leave one per cycle on a valid/ready stream. The block counts the acknowledgements that come back and reports completion with a single-cycle `done`.

Controller states:
- `ST_IDLE` accepts a request.
- `ST_SEND` walks the target space: the pointer slots, every node, or a single eviction victim.
- `ST_WAIT` holds until every issued invalidation has been acknowledged.
- `ST_FINISH` writes the entry back and pulses `done`.

Transitions:
- IDLE→SEND when a request needs invalidations.
- IDLE→FINISH when it needs none.
- SEND→WAIT after the last target position.
- WAIT→FINISH when the outstanding count is zero.
- FINISH→IDLE always.

Top module: `ptr_directory`

## Requirements
- R1: After reset `req_ready` is 1, `inv_valid` and `done` are 0, `acks_outstanding` is 0, and every entry is empty, so a first write to any line produces no invalidation.
- R2: A read from a node not listed, when a pointer slot is free, takes the lowest free slot, sends no invalidation and completes with one `done` pulse.
- R3: A read from a node already held in a pointer allocates no second slot and sends no invalidation.
- R4: With `BCAST_MODE = 0`, a read from an unlisted node when all slots are full sends exactly one invalidation, to the node in the slot named by the round-robin index. That slot then holds the reader, and the index advances by one, wrapping from the last slot to slot 0.
- R5: With `BCAST_MODE = 1`, such an overflowing read sends no invalidation and sets the overflow flag. Further unlisted readers are not recorded. The next write invalidates every node number `0..NODES-1` except the writer.
- R6: A write on a line without the overflow flag invalidates each node held in a valid pointer, except the writer itself.
- R7: When a write completes, the entry holds only the writer (slot 0), the overflow flag is clear, and `rsp_dirty` is 1 during `done`.
- R8: A read clears the modified flag. `rsp_dirty` is 0 during the `done` of every read, and a previous exclusive owner stays listed as a sharer.
- R9: Invalidations are issued at most one per cycle. Each target appears exactly once per operation. While `inv_valid` is high and `inv_ready` is low, `inv_valid` and `inv_node` hold.
- R10: `acks_outstanding` equals the invalidations issued minus the `ack_valid` pulses received in the current operation. `done` is raised only once this count is zero.
- R11: Entries of different lines are independent; an operation on one line leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_write | input | 1 | 1 = exclusive write, 0 = shared read |
| req_node | input | log2(NODES) | Requesting node number |
| req_line | input | log2(LINES) | Line index |
| inv_valid | output | 1 | Invalidation target present |
| inv_ready | input | 1 | Target accepted by transport |
| inv_node | output | log2(NODES) | Node to invalidate |
| ack_valid | input | 1 | One invalidation acknowledged |
| acks_outstanding | output | log2(NODES+1) | Issued minus acknowledged invalidations |
| done | output | 1 | Operation complete, entry updated |
| rsp_dirty | output | 1 | Modified flag of the updated entry, valid with `done` |

## Verification
The states that are hardest to reach are the full pointer set and, in overflow mode, the overflow flag. Both need more distinct readers on one line than there are slots, with no intervening write. Beyond that, the eviction index has to be driven around its wrap point. The bench runs two instances, one per overflow mode, side by side on four nodes, two slots and two lines. Directed sequences pack three and four readers onto a line, then sweep a long arithmetic stream of reads and writes across both lines. A reference entry model predicts every target set. The invalidation stream is throttled with a periodic `inv_ready` pattern, and acknowledgements return one cycle late, so the hold and drain rules are exercised on every multi-target write.

// File: rtl/ptrdir_pkg.sv
package ptrdir_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_FINISH
    } dir_state_e;

    typedef enum logic [1:0] {
        SC_PTRS,
        SC_ALL,
        SC_ONE
    } scan_e;

    typedef enum logic [1:0] {
        RD_KEEP,
        RD_ALLOC,
        RD_EVICT,
        RD_WIDEN
    } rd_act_e;

endpackage

// File: rtl/ptrdir_store.sv
module ptrdir_store #(
    parameter int NW    = 2,
    parameter int PTRS  = 2,
    parameter int PW    = 1,
    parameter int LINES = 2,
    parameter int LW    = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LW-1:0]            rd_line,
    output logic [PTRS-1:0][NW-1:0]  rd_ptr,
    output logic [PTRS-1:0]          rd_vld,
    output logic                     rd_bc,
    output logic                     rd_dirty,
    output logic [PW-1:0]            rd_rr,
    input  logic                     wr_en,
    input  logic [LW-1:0]            wr_line,
    input  logic [PTRS-1:0][NW-1:0]  wr_ptr,
    input  logic [PTRS-1:0]          wr_vld,
    input  logic                     wr_bc,
    input  logic                     wr_dirty,
    input  logic [PW-1:0]            wr_rr
);

    logic [PTRS-1:0][NW-1:0] mem_ptr   [LINES];
    logic [PTRS-1:0]         mem_vld   [LINES];
    logic                    mem_bc    [LINES];
    logic                    mem_dirty [LINES];
    logic [PW-1:0]           mem_rr    [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < LINES; l++) begin
                mem_ptr[l]   <= '0;
                mem_vld[l]   <= '0;
                mem_bc[l]    <= 1'b0;
                mem_dirty[l] <= 1'b0;
                mem_rr[l]    <= '0;
            end
        end else if (wr_en) begin
            mem_ptr[wr_line]   <= wr_ptr;
            mem_vld[wr_line]   <= wr_vld;
            mem_bc[wr_line]    <= wr_bc;
            mem_dirty[wr_line] <= wr_dirty;
            mem_rr[wr_line]    <= wr_rr;
        end
    end

    assign rd_ptr   = mem_ptr[rd_line];
    assign rd_vld   = mem_vld[rd_line];
    assign rd_bc    = mem_bc[rd_line];
    assign rd_dirty = mem_dirty[rd_line];
    assign rd_rr    = mem_rr[rd_line];

endmodule

// File: rtl/ptrdir_match.sv
module ptrdir_match #(
    parameter int NW   = 2,
    parameter int PTRS = 2,
    parameter int PW   = 1
) (
    input  logic [PTRS-1:0][NW-1:0] ptr,
    input  logic [PTRS-1:0]         vld,
    input  logic [NW-1:0]           node,
    output logic                    hit,
    output logic                    any_free,
    output logic [PW-1:0]           free_slot
);

    logic [PTRS-1:0] eq;

    for (genvar g = 0; g < PTRS; g++) begin : g_cmp
        assign eq[g] = vld[g] && (ptr[g] == node);
    end

    assign hit = |eq;

    always_comb begin
        any_free  = 1'b0;
        free_slot = '0;
        for (int s = PTRS - 1; s >= 0; s--) begin
            if (!vld[s]) begin
                any_free  = 1'b1;
                free_slot = PW'(s);
            end
        end
    end

endmodule

// File: rtl/ptr_directory.sv
module ptr_directory
    import ptrdir_pkg::*;
#(
    parameter int NODES      = 4,
    parameter int PTRS       = 2,
    parameter int LINES      = 2,
    parameter bit BCAST_MODE = 1'b0,
    localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int LW = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int CW = $clog2(NODES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [NW-1:0] req_node,
    input  logic [LW-1:0] req_line,
    output logic          inv_valid,
    input  logic          inv_ready,
    output logic [NW-1:0] inv_node,
    input  logic          ack_valid,
    output logic [CW-1:0] acks_outstanding,
    output logic          done,
    output logic          rsp_dirty
);

    localparam int PW = (PTRS > 1) ? $clog2(PTRS) : 1;

    dir_state_e state_q, state_d;
    scan_e      kind_q, dec_kind;
    rd_act_e    act_q, dec_act;

    logic          cur_write;
    logic [NW-1:0] cur_node;
    logic [LW-1:0] cur_line;
    logic [PW-1:0] slot_q, dec_slot;
    logic [NW-1:0] cursor_q;
    logic [CW-1:0] issued_q, rcvd_q;
    logic          go_send;

    logic [PTRS-1:0][NW-1:0] e_ptr, w_ptr;
    logic [PTRS-1:0]         e_vld, w_vld;
    logic                    e_bc, e_dirty, w_bc, w_dirty;
    logic [PW-1:0]           e_rr, w_rr;
    logic                    hit, any_free;
    logic [PW-1:0]           free_slot;
    logic [LW-1:0]           rd_line;

    logic          is_tgt, last_pos, step, accept;
    logic [NW-1:0] tgt;
    logic [PW-1:0] ptr_idx;

    assign rd_line = (state_q == ST_IDLE) ? req_line : cur_line;

    ptrdir_store #(.NW(NW), .PTRS(PTRS), .PW(PW), .LINES(LINES), .LW(LW)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_line(rd_line),
        .rd_ptr(e_ptr), .rd_vld(e_vld), .rd_bc(e_bc), .rd_dirty(e_dirty), .rd_rr(e_rr),
        .wr_en(state_q == ST_FINISH), .wr_line(cur_line),
        .wr_ptr(w_ptr), .wr_vld(w_vld), .wr_bc(w_bc), .wr_dirty(w_dirty), .wr_rr(w_rr)
    );

    ptrdir_match #(.NW(NW), .PTRS(PTRS), .PW(PW)) u_match (
        .ptr(e_ptr), .vld(e_vld), .node(req_node),
        .hit(hit), .any_free(any_free), .free_slot(free_slot)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    // Request decode, evaluated against the entry of the incoming line.
    always_comb begin
        dec_act  = RD_KEEP;
        dec_slot = '0;
        dec_kind = SC_PTRS;
        go_send  = 1'b0;
        if (req_write) begin
            go_send  = 1'b1;
            dec_kind = e_bc ? SC_ALL : SC_PTRS;
        end else if (hit || e_bc) begin
            dec_act = RD_KEEP;
        end else if (any_free) begin
            dec_act  = RD_ALLOC;
            dec_slot = free_slot;
        end else if (BCAST_MODE) begin
            dec_act = RD_WIDEN;
        end else begin
            dec_act  = RD_EVICT;
            dec_slot = e_rr;
            dec_kind = SC_ONE;
            go_send  = 1'b1;
        end
    end

    // Target walk.
    assign ptr_idx = cursor_q[PW-1:0];
    always_comb begin
        tgt      = '0;
        is_tgt   = 1'b0;
        last_pos = 1'b1;
        unique case (kind_q)
            SC_PTRS: begin
                tgt      = e_ptr[ptr_idx];
                is_tgt   = e_vld[ptr_idx] && (e_ptr[ptr_idx] != cur_node);
                last_pos = (cursor_q == NW'(PTRS - 1));
            end
            SC_ALL: begin
                tgt      = cursor_q;
                is_tgt   = (cursor_q != cur_node);
                last_pos = (cursor_q == NW'(NODES - 1));
            end
            SC_ONE: begin
                tgt      = e_ptr[slot_q];
                is_tgt   = 1'b1;
                last_pos = 1'b1;
            end
            default: ;
        endcase
    end

    assign step = (state_q == ST_SEND) && (!is_tgt || inv_ready);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = go_send ? ST_SEND : ST_FINISH;
            ST_SEND:   if (step && last_pos) state_d = ST_WAIT;
            ST_WAIT:   if (issued_q == rcvd_q) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            cur_node  <= '0;
            cur_line  <= '0;
            act_q     <= RD_KEEP;
            kind_q    <= SC_PTRS;
            slot_q    <= '0;
            cursor_q  <= '0;
            issued_q  <= '0;
            rcvd_q    <= '0;
        end else if (accept) begin
            cur_write <= req_write;
            cur_node  <= req_node;
            cur_line  <= req_line;
            act_q     <= dec_act;
            kind_q    <= dec_kind;
            slot_q    <= dec_slot;
            cursor_q  <= '0;
            issued_q  <= '0;
            rcvd_q    <= '0;
        end else begin
            if (step) cursor_q <= cursor_q + 1'b1;
            if (step && is_tgt) issued_q <= issued_q + 1'b1;
            if (ack_valid) rcvd_q <= rcvd_q + 1'b1;
        end
    end

    // Entry write-back, applied in ST_FINISH.
    always_comb begin
        w_ptr   = e_ptr;
        w_vld   = e_vld;
        w_bc    = e_bc;
        w_dirty = 1'b0;
        w_rr    = e_rr;
        if (cur_write) begin
            w_ptr[0] = cur_node;
            w_vld    = PTRS'(1);
            w_bc     = 1'b0;
            w_dirty  = 1'b1;
        end else begin
            unique case (act_q)
                RD_ALLOC: begin
                    w_ptr[slot_q] = cur_node;
                    w_vld[slot_q] = 1'b1;
                end
                RD_EVICT: begin
                    w_ptr[slot_q] = cur_node;
                    w_rr = (slot_q == PW'(PTRS - 1)) ? '0 : slot_q + 1'b1;
                end
                RD_WIDEN: w_bc = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        req_ready        = (state_q == ST_IDLE);
        inv_valid        = (state_q == ST_SEND) && is_tgt;
        inv_node         = tgt;
        done             = (state_q == ST_FINISH);
        rsp_dirty        = (state_q == ST_FINISH) && w_dirty;
        acks_outstanding = issued_q - rcvd_q;
    end

endmodule

// File: rtl/ptrdir_chk.sv
module ptrdir_chk #(
    parameter int NW = 2,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          inv_valid,
    input logic          inv_ready,
    input logic [NW-1:0] inv_node,
    input logic [NW-1:0] cur_node,
    input logic [CW-1:0] acks_outstanding,
    input logic          done,
    input logic          rsp_dirty
);

    p_inv_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && !inv_ready |=> inv_valid && $stable(inv_node));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !inv_valid);

    p_writer_excluded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> inv_node != cur_node);

    p_done_drained_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> acks_outstanding == '0);

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_dirty_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_dirty |-> done);

endmodule

bind ptr_directory ptrdir_chk #(.NW(NW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_node(inv_node),
    .cur_node(cur_node), .acks_outstanding(acks_outstanding),
    .done(done), .rsp_dirty(rsp_dirty)
);

// File: tb/sim_ptr_directory.sv
module sim_ptr_directory;

    localparam int CLK_PERIOD = 10;
    localparam int NODES = 4;
    localparam int PTRS  = 2;
    localparam int LINES = 2;
    localparam int NW = 2;
    localparam int LW = 1;
    localparam int CW = 3;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [NW-1:0] req_node = '0;
    logic [LW-1:0] req_line = '0;

    logic rdy_a, rdy_b, iv_a, iv_b, done_a, done_b, dty_a, dty_b;
    logic ir_a = 1'b0, ir_b = 1'b0, ack_a = 1'b0, ack_b = 1'b0;
    logic [NW-1:0] in_a, in_b;
    logic [CW-1:0] out_a, out_b;

    int errors = 0, checks = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_directory #(.NODES(NODES), .PTRS(PTRS), .LINES(LINES), .BCAST_MODE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_a),
        .req_write(req_write), .req_node(req_node), .req_line(req_line),
        .inv_valid(iv_a), .inv_ready(ir_a), .inv_node(in_a), .ack_valid(ack_a),
        .acks_outstanding(out_a), .done(done_a), .rsp_dirty(dty_a));

    ptr_directory #(.NODES(NODES), .PTRS(PTRS), .LINES(LINES), .BCAST_MODE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_b),
        .req_write(req_write), .req_node(req_node), .req_line(req_line),
        .inv_valid(iv_b), .inv_ready(ir_b), .inv_node(in_b), .ack_valid(ack_b),
        .acks_outstanding(out_b), .done(done_b), .rsp_dirty(dty_b));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: throttled ready, delayed acks, target capture, hold check.
    int  mask_a, mask_b, cnt_a, cnt_b, sent_a, sent_b, sent_done_a, sent_done_b;
    bit  seen_a, seen_b, rd_dty_a, rd_dty_b, pend_a, pend_b, stall_a, stall_b;
    logic [NW-1:0] hold_a, hold_b;

    always @(negedge clk) begin
        if (!rst_n) begin
            pend_a = 0; pend_b = 0; stall_a = 0; stall_b = 0;
        end else begin
            if (stall_a) check(iv_a && in_a == hold_a, "R9 hold u0", int'(in_a), int'(hold_a));
            if (stall_b) check(iv_b && in_b == hold_b, "R9 hold u1", int'(in_b), int'(hold_b));
            ack_a = pend_a; ack_b = pend_b;
            if (pend_a) sent_a++;
            if (pend_b) sent_b++;
            ir_a = (cyc % 3) != 1;
            ir_b = (cyc % 4) != 2;
            pend_a = iv_a && ir_a;
            pend_b = iv_b && ir_b;
            if (pend_a) begin mask_a |= (1 << in_a); cnt_a++; end
            if (pend_b) begin mask_b |= (1 << in_b); cnt_b++; end
            stall_a = iv_a && !ir_a; hold_a = in_a;
            stall_b = iv_b && !ir_b; hold_b = in_b;
            if (done_a) begin seen_a = 1; rd_dty_a = dty_a; sent_done_a = sent_a; end
            if (done_b) begin seen_b = 1; rd_dty_b = dty_b; sent_done_b = sent_b; end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Reference entry model, one per overflow mode.
    int m_ptr [2][LINES][PTRS];
    bit m_vld [2][LINES][PTRS];
    bit m_bc  [2][LINES];
    bit m_dty [2][LINES];
    int m_rr  [2][LINES];

    task automatic model_op(input int md, input bit w, input int nd, input int ln,
                            output int mask, output bit dty, output string tag);
        bit hit = 0;
        int fs = -1;
        mask = 0;
        if (w) begin
            tag = m_bc[md][ln] ? "R5" : "R6";
            if (m_bc[md][ln]) begin
                for (int n = 0; n < NODES; n++) if (n != nd) mask |= (1 << n);
            end else begin
                for (int s = 0; s < PTRS; s++)
                    if (m_vld[md][ln][s] && m_ptr[md][ln][s] != nd) mask |= (1 << m_ptr[md][ln][s]);
            end
            for (int s = 0; s < PTRS; s++) m_vld[md][ln][s] = (s == 0);
            m_ptr[md][ln][0] = nd;
            m_bc[md][ln] = 0;
            m_dty[md][ln] = 1;
        end else begin
            m_dty[md][ln] = 0;
            for (int s = PTRS - 1; s >= 0; s--) begin
                if (m_vld[md][ln][s] && m_ptr[md][ln][s] == nd) hit = 1;
                if (!m_vld[md][ln][s]) fs = s;
            end
            if (hit) tag = "R3";
            else if (m_bc[md][ln]) tag = "R5";
            else if (fs >= 0) begin
                tag = "R2";
                m_ptr[md][ln][fs] = nd;
                m_vld[md][ln][fs] = 1;
            end else if (md == 0) begin
                tag = "R4";
                mask = 1 << m_ptr[md][ln][m_rr[md][ln]];
                m_ptr[md][ln][m_rr[md][ln]] = nd;
                m_rr[md][ln] = (m_rr[md][ln] + 1) % PTRS;
            end else begin
                tag = "R5";
                m_bc[md][ln] = 1;
            end
        end
        dty = m_dty[md][ln];
    endtask

    task automatic do_op(input bit w, input int nd, input int ln, input string ctx);
        int ea, eb;
        bit da, db;
        string ta, tb;
        model_op(0, w, nd, ln, ea, da, ta);
        model_op(1, w, nd, ln, eb, db, tb);
        @(negedge clk);
        mask_a = 0; mask_b = 0; cnt_a = 0; cnt_b = 0;
        sent_a = 0; sent_b = 0; seen_a = 0; seen_b = 0;
        req_valid = 1; req_write = w; req_node = NW'(nd); req_line = LW'(ln);
        @(negedge clk);
        req_valid = 0;
        do @(posedge clk); while (!(seen_a && seen_b));
        check(mask_a == ea, {ta, " targets u0 ", ctx}, mask_a, ea);
        check(mask_b == eb, {tb, " targets u1 ", ctx}, mask_b, eb);
        check(cnt_a == $countones(ea), "R9 count u0", cnt_a, $countones(ea));
        check(cnt_b == $countones(eb), "R9 count u1", cnt_b, $countones(eb));
        check(rd_dty_a == da, w ? "R7 dirty u0" : "R8 dirty u0", rd_dty_a, da);
        check(rd_dty_b == db, w ? "R7 dirty u1" : "R8 dirty u1", rd_dty_b, db);
        check(sent_done_a == cnt_a, "R10 acks before done u0", sent_done_a, cnt_a);
        check(sent_done_b == cnt_b, "R10 acks before done u1", sent_done_b, cnt_b);
    endtask

    initial begin
        for (int m = 0; m < 2; m++)
            for (int l = 0; l < LINES; l++) begin
                m_bc[m][l] = 0; m_dty[m][l] = 0; m_rr[m][l] = 0;
                for (int s = 0; s < PTRS; s++) begin m_vld[m][l][s] = 0; m_ptr[m][l][s] = 0; end
            end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(rdy_a && rdy_b, "R1 ready", int'(rdy_a && rdy_b), 1);
        check(!iv_a && !iv_b, "R1 inv_valid", int'(iv_a || iv_b), 0);
        check(!done_a && !done_b, "R1 done", int'(done_a || done_b), 0);
        check(out_a == 0 && out_b == 0, "R1 outstanding", int'(out_a) + int'(out_b), 0);
        do_op(1, 1, 0, "R1 first write");
        // R2/R3/R8: sharers join, repeat reader and previous owner hit
        do_op(0, 2, 0, "R2 alloc");
        do_op(0, 2, 0, "R3 repeat");
        do_op(0, 1, 0, "R3 owner");
        // R4/R5: overflow, round-robin wrap
        do_op(0, 3, 0, "R4 overflow slot0");
        do_op(0, 0, 0, "R4 overflow slot1");
        do_op(0, 1, 0, "R4 wrap");
        // R5/R6: write after overflow, writer excluded
        do_op(1, 0, 0, "R6 write");
        // R7: owner replaced by next writer
        do_op(1, 3, 0, "R7 rewrite");
        // R11: other line untouched by line 0 traffic
        do_op(1, 2, 1, "R11 line1 write");
        do_op(0, 0, 1, "R11 line1 read");
        // Near-exhaustive arithmetic sweep
        for (int k = 0; k < 240; k++)
            do_op(k % 5 == 2, (k * 3 + k / 4) % NODES, (k / 9) % LINES, "R11 sweep");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule